// File: doc/BRIEF.md
# Partition-Aware Burst Loader

This block moves a contiguous run of 32-bit elements from a memory read port into a scratchpad that is split cyclically over four banks. A caller gives a byte start address, an element count and a destination element offset, then pulses start. The loader raises one burst request carrying the address and the number of 64-bit beats. It then waits for the memory side to return data.

Every returned beat holds two elements. The loader writes both halves into two different banks in the same clock cycle, so a stream of back-to-back beats fills the scratchpad at two elements per cycle with no gaps added by the loader. Element number k of the destination goes to bank k mod 4, at row k div 4. When the final pair has been written, the loader drops busy and pulses done for one cycle.

Typical uses are a 16-element matrix fetched from a base address and a 4-element vector fetched from that base plus 64 bytes. The memory side may take 15 cycles or more before its first beat arrives.

Top module: `burst_bank_loader`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, busy, done, the request valid and all four bank write enables are low.
- R2: A start pulse seen while idle captures the address, count and offset and raises busy from the next cycle. A start pulse seen while busy has no effect on the running transfer or on its parameters.
- R3: Exactly one request is raised per transfer, from the cycle after start until the cycle after the handshake (valid and ready both high). It carries the start byte address, which must be 8-byte aligned, and a beat count equal to the element count divided by two. The count must be even and nonzero.
- R4: Destination element k = offset + i receives source element i, with k taken modulo the scratchpad size of 64 elements. It is written to bank k mod 4 at row k div 4.
- R5: For each accepted beat, bits 31:0 carry the lower-numbered element and bits 63:32 carry the next one. Both are written in the single cycle after the beat is accepted, with exactly two bank enables high.
- R6: Beats arriving on consecutive cycles produce bank writes on consecutive cycles, with no idle cycle inserted by the loader.
- R7: Done is high for exactly one cycle, in the cycle after the final bank write. Busy is low in that same cycle.
- R8: Response beats that arrive while idle, or before the request handshake, cause no bank write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startI | input | 1 | Start pulse |
| srcAddrI | input | ADDR_W | Source byte address, 8-byte aligned |
| elemCntI | input | CNT_W | Number of 32-bit elements, even |
| dstOffI | input | ROW_W+2 | Destination element offset in the scratchpad |
| busyO | output | 1 | Transfer in progress |
| doneO | output | 1 | One-cycle completion pulse |
| memReqValidO | output | 1 | Burst request valid |
| memReqReadyI | input | 1 | Burst request accepted |
| memReqAddrO | output | ADDR_W | Burst start byte address |
| memReqBeatsO | output | CNT_W | Number of 64-bit beats requested |
| memRspValidI | input | 1 | Response beat valid |
| memRspDataI | input | 2*ELEM_W | Response beat, two elements |
| bankWrEnO | output | NUM_BANKS | Per-bank write enable |
| bankWrRowO | output | NUM_BANKS*ROW_W | Per-bank row index, bank b at bits b*ROW_W upward |
| bankWrDataO | output | NUM_BANKS*ELEM_W | Per-bank write data, bank b at bits b*ELEM_W upward |

## Verification
The hardest situation to reach from the ports is a destination offset that does not start on a bank boundary. With such an offset, a beat's two halves land in banks 3 and 0 on different rows, and the index wraps past the end of the scratchpad in the middle of a transfer. The stimulus reaches it with odd offsets and an offset near the top of the scratchpad. It also sends bursts both back-to-back and with a gap, and it pulses start with different parameters during the latency wait, so that a wrongly latched start would corrupt the later writes. A cycle-level reference model in the bench predicts every output on every clock.

// File: rtl/burst_ld_pkg.sv
package burst_ld_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_DATA  = 2'd2,
    ST_FLUSH = 2'd3
  } ldStateT;

  // Strobes from control to datapath
  typedef struct packed {
    logic cfgLoad;   // capture transfer parameters
    logic beatTake;  // accept one response beat
  } ldStrobeT;

endpackage

// File: rtl/burst_ld_ctrl.sv
module burst_ld_ctrl
  import burst_ld_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startI,
  input  logic     memReqReadyI,
  input  logic     memRspValidI,
  input  logic     lastBeatI,
  output ldStrobeT strobeO,
  output logic     busyO,
  output logic     doneO,
  output logic     memReqValidO
);

  ldStateT stateQ, stateD;
  logic    doneQ;

  always_comb begin
    strobeO.cfgLoad  = (stateQ == ST_IDLE) && startI;
    strobeO.beatTake = (stateQ == ST_DATA) && memRspValidI;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:  if (startI) stateD = ST_REQ;
      ST_REQ:   if (memReqReadyI) stateD = ST_DATA;
      ST_DATA:  if (memRspValidI && lastBeatI) stateD = ST_FLUSH;
      ST_FLUSH: stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= (stateQ == ST_FLUSH);
    end
  end

  assign busyO        = (stateQ != ST_IDLE);
  assign doneO        = doneQ;
  assign memReqValidO = (stateQ == ST_REQ);

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (startI && !busyO) |=> busyO);  // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValidO && !memReqReadyI) |=> memReqValidO);  // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneO |=> !doneO);  // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    doneO |-> !busyO);  // R7

endmodule

// File: rtl/burst_ld_datapath.sv
module burst_ld_datapath
  import burst_ld_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 8,
  parameter int ELEM_W    = 32,
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 4,
  localparam int BS_W     = $clog2(NUM_BANKS),
  localparam int IDX_W    = ROW_W + BS_W,
  localparam int BEAT_W   = 2 * ELEM_W
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ldStrobeT                      strobeI,
  input  logic [ADDR_W-1:0]             srcAddrI,
  input  logic [CNT_W-1:0]              elemCntI,
  input  logic [IDX_W-1:0]              dstOffI,
  input  logic [BEAT_W-1:0]             memRspDataI,
  output logic [ADDR_W-1:0]             reqAddrO,
  output logic [CNT_W-1:0]              reqBeatsO,
  output logic                          lastBeatO,
  output logic [NUM_BANKS-1:0]          bankWrEnO,
  output logic [NUM_BANKS*ROW_W-1:0]    bankWrRowO,
  output logic [NUM_BANKS*ELEM_W-1:0]   bankWrDataO
);

  logic [ADDR_W-1:0] addrQ;
  logic [CNT_W-1:0]  beatsQ, beatsLeftQ;
  logic [IDX_W-1:0]  loIdx, hiIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ      <= '0;
      beatsQ     <= '0;
      beatsLeftQ <= '0;
      loIdx      <= '0;
    end else if (strobeI.cfgLoad) begin
      addrQ      <= srcAddrI;
      beatsQ     <= elemCntI >> 1;
      beatsLeftQ <= elemCntI >> 1;
      loIdx      <= dstOffI;
    end else if (strobeI.beatTake) begin
      beatsLeftQ <= beatsLeftQ - CNT_W'(1);
      loIdx      <= loIdx + IDX_W'(2);
    end
  end

  assign hiIdx     = loIdx + IDX_W'(1);
  assign reqAddrO  = addrQ;
  assign reqBeatsO = beatsQ;
  assign lastBeatO = (beatsLeftQ == CNT_W'(1));

  for (genvar g = 0; g < NUM_BANKS; g++) begin : gBank
    logic              hitLo, hitHi;
    logic              enQ;
    logic [ROW_W-1:0]  rowQ;
    logic [ELEM_W-1:0] dataQ;

    assign hitLo = (loIdx[BS_W-1:0] == BS_W'(g));
    assign hitHi = (hiIdx[BS_W-1:0] == BS_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        enQ   <= 1'b0;
        rowQ  <= '0;
        dataQ <= '0;
      end else begin
        enQ <= strobeI.beatTake && (hitLo || hitHi);
        if (strobeI.beatTake && hitLo) begin
          rowQ  <= loIdx[IDX_W-1:BS_W];
          dataQ <= memRspDataI[ELEM_W-1:0];
        end else if (strobeI.beatTake && hitHi) begin
          rowQ  <= hiIdx[IDX_W-1:BS_W];
          dataQ <= memRspDataI[BEAT_W-1:ELEM_W];
        end
      end
    end

    assign bankWrEnO[g]                       = enQ;
    assign bankWrRowO[g*ROW_W +: ROW_W]       = rowQ;
    assign bankWrDataO[g*ELEM_W +: ELEM_W]    = dataQ;
  end

  AST_PAIR_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (bankWrEnO == '0) || ($countones(bankWrEnO) == 2));  // R5
  AST_NO_BUBBLE: assert property (@(posedge clk) disable iff (!rstN)
    strobeI.beatTake |=> ($countones(bankWrEnO) == 2));  // R6
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !strobeI.beatTake |=> (bankWrEnO == '0));  // R8

endmodule

// File: rtl/burst_bank_loader.sv
module burst_bank_loader
  import burst_ld_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 8,
  parameter int ELEM_W    = 32,
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 4
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  startI,
  input  logic [ADDR_W-1:0]                     srcAddrI,
  input  logic [CNT_W-1:0]                      elemCntI,
  input  logic [ROW_W+$clog2(NUM_BANKS)-1:0]    dstOffI,
  output logic                                  busyO,
  output logic                                  doneO,
  output logic                                  memReqValidO,
  input  logic                                  memReqReadyI,
  output logic [ADDR_W-1:0]                     memReqAddrO,
  output logic [CNT_W-1:0]                      memReqBeatsO,
  input  logic                                  memRspValidI,
  input  logic [2*ELEM_W-1:0]                   memRspDataI,
  output logic [NUM_BANKS-1:0]                  bankWrEnO,
  output logic [NUM_BANKS*ROW_W-1:0]            bankWrRowO,
  output logic [NUM_BANKS*ELEM_W-1:0]           bankWrDataO
);

  ldStrobeT strobe;
  logic     lastBeat;

  burst_ld_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .startI       (startI),
    .memReqReadyI (memReqReadyI),
    .memRspValidI (memRspValidI),
    .lastBeatI    (lastBeat),
    .strobeO      (strobe),
    .busyO        (busyO),
    .doneO        (doneO),
    .memReqValidO (memReqValidO)
  );

  burst_ld_datapath #(
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W),
    .ELEM_W    (ELEM_W),
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ROW_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobeI     (strobe),
    .srcAddrI    (srcAddrI),
    .elemCntI    (elemCntI),
    .dstOffI     (dstOffI),
    .memRspDataI (memRspDataI),
    .reqAddrO    (memReqAddrO),
    .reqBeatsO   (memReqBeatsO),
    .lastBeatO   (lastBeat),
    .bankWrEnO   (bankWrEnO),
    .bankWrRowO  (bankWrRowO),
    .bankWrDataO (bankWrDataO)
  );

endmodule

// File: tb/burst_bank_loader_tb.sv
module burst_bank_loader_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startI = 1'b0;
  logic [31:0] srcAddrI = '0;
  logic [7:0]  elemCntI = '0;
  logic [5:0]  dstOffI = '0;
  logic        memReqReadyI = 1'b0;
  logic        memRspValidI = 1'b0;
  logic [63:0] memRspDataI = '0;
  logic        busyO, doneO, memReqValidO;
  logic [31:0] memReqAddrO;
  logic [7:0]  memReqBeatsO;
  logic [3:0]  bankWrEnO;
  logic [15:0] bankWrRowO;
  logic [127:0] bankWrDataO;

  always #4 clk = ~clk;  // 125 MHz

  burst_bank_loader dut_i (
    .clk(clk), .rstN(rstN), .startI(startI), .srcAddrI(srcAddrI),
    .elemCntI(elemCntI), .dstOffI(dstOffI), .busyO(busyO), .doneO(doneO),
    .memReqValidO(memReqValidO), .memReqReadyI(memReqReadyI),
    .memReqAddrO(memReqAddrO), .memReqBeatsO(memReqBeatsO),
    .memRspValidI(memRspValidI), .memRspDataI(memRspDataI),
    .bankWrEnO(bankWrEnO), .bankWrRowO(bankWrRowO), .bankWrDataO(bankWrDataO)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit running = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // Reference model, updated on each rising edge
  int          ph = 0;          // 0 idle, 1 request, 2 data, 3 flush
  int          mAddr, mBeats, mLeft, mK;
  bit          expBusy, expDone, expReq, strayRsp;
  bit [3:0]    expEn;
  int          expRow [4];
  logic [31:0] expData [4];

  always @(posedge clk) begin
    if (!rstN) begin
      ph = 0; expBusy = 0; expDone = 0; expReq = 0; expEn = '0; strayRsp = 0;
    end else begin
      expEn = '0; expDone = 0; strayRsp = 0;
      case (ph)
        0: begin
          if (memRspValidI) strayRsp = 1;
          if (startI) begin
            mAddr = srcAddrI; mBeats = elemCntI / 2; mLeft = mBeats;
            mK = dstOffI; ph = 1;
          end
        end
        1: begin
          if (memRspValidI) strayRsp = 1;
          if (memReqReadyI) ph = 2;
        end
        2: if (memRspValidI) begin
          int lo, hi;
          lo = mK % 64; hi = (mK + 1) % 64;
          expEn[lo % 4] = 1; expRow[lo % 4] = lo / 4; expData[lo % 4] = memRspDataI[31:0];
          expEn[hi % 4] = 1; expRow[hi % 4] = hi / 4; expData[hi % 4] = memRspDataI[63:32];
          mK = (mK + 2) % 64; mLeft--;
          if (mLeft == 0) ph = 3;
        end
        3: begin ph = 0; expDone = 1; end
        default: ph = 0;
      endcase
      expBusy = (ph != 0);
      expReq  = (ph == 1);
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (running) begin
      chk("R2", "busy", busyO, expBusy);
      chk("R7", "done", doneO, expDone);
      chk("R3", "reqValid", memReqValidO, expReq);
      if (expReq) begin
        chk("R3", "reqAddr", memReqAddrO, mAddr);
        chk("R3", "reqBeats", memReqBeatsO, mBeats);
      end
      chk(strayRsp ? "R8" : "R6", "bankWrEn", bankWrEnO, expEn);
      for (int b = 0; b < 4; b++) begin
        if (expEn[b]) begin
          chk("R4", $sformatf("bank%0d row", b), bankWrRowO[b*4 +: 4], expRow[b]);
          chk("R5", $sformatf("bank%0d data", b), bankWrDataO[b*32 +: 32], expData[b]);
        end
      end
    end
  end

  function automatic logic [31:0] memElem(int a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  task automatic runXfer(int addr, int cnt, int off, int rdyDelay, bit gap, bit poke);
    @(negedge clk);
    startI = 1; srcAddrI = addr; elemCntI = cnt[7:0]; dstOffI = off[5:0];
    @(negedge clk);
    startI = 0;
    repeat (rdyDelay) @(negedge clk);
    memReqReadyI = 1;
    @(negedge clk);
    memReqReadyI = 0;
    for (int i = 0; i < 14; i++) begin
      if (poke && i == 3) begin
        startI = 1; srcAddrI = 32'h0000_7700; elemCntI = 8'd2; dstOffI = 6'd33;
      end else begin
        startI = 0;
      end
      @(negedge clk);
    end
    startI = 0;
    for (int b = 0; b < cnt / 2; b++) begin
      if (gap && b == 2) begin
        memRspValidI = 0;
        @(negedge clk);
      end
      memRspValidI = 1;
      memRspDataI  = {memElem(addr + 8*b + 4), memElem(addr + 8*b)};
      @(negedge clk);
    end
    memRspValidI = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", busyO, 0);
    chk("R1", "done in reset", doneO, 0);
    chk("R1", "reqValid in reset", memReqValidO, 0);
    chk("R1", "bankWrEn in reset", bankWrEnO, 0);
    rstN = 1;
    @(negedge clk);
    chk("R1", "busy after reset", busyO, 0);
    chk("R1", "bankWrEn after reset", bankWrEnO, 0);
    running = 1;
    runXfer(32'h1000, 16, 0, 0, 0, 0);       // matrix, aligned offset
    runXfer(32'h1040, 4, 16, 2, 0, 0);       // vector, base plus 64 bytes
    runXfer(32'h2000, 16, 5, 1, 1, 1);       // odd offset, gap, ignored start
    // stray response beats while idle (R8)
    for (int i = 0; i < 3; i++) begin
      memRspValidI = 1; memRspDataI = 64'hDEAD_BEEF_0BAD_F00D;
      @(negedge clk);
    end
    memRspValidI = 0;
    runXfer(32'h3008, 8, 60, 0, 0, 0);       // wraps past end of scratchpad
    runXfer(32'h4000, 2, 3, 3, 0, 0);        // single beat, banks 3 and 0
    running = 0;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule